// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Unit

This unit carries out the external refill of one data cache line after a miss. It accepts a miss that names a line address and the index of the word the core is waiting for. It issues one burst read to external memory that starts at that word. The burst then returns the rest of the line in wrap-around order. Each returning word is captured in a line fill buffer and written into the cache data array on the following cycle. The first word to arrive is the one the core needs, and it can be handed to the waiting requester in that same cycle.

While the fill runs, the core keeps working. Loads and stores to other lines hit in the cache array as usual. Words of the line being filled that have already arrived can be read from the fill buffer through a lookup port. A requester that goes away, for example because an interrupt cancels a stalled load, stops only the forwarding. The fill always runs to the end. The line's tag is written valid only after its last word is in the array. Any new miss is held off until that tag write is done, so a cancelled fill always lands before the next miss is serviced.

Top module: `lfu_line_fill`

## Requirements
- R1: After reset, `miss_ready` is 1 and `busy`, `ext_req_valid`, `cwr_en`, `fwd_valid` and `tag_wr_en` are all 0.
- R2: In the cycle after a miss is accepted (`miss_valid` and `miss_ready` both high at a clock edge), `ext_req_valid` is 1 and carries the miss line on `ext_req_line` and the critical word index on `ext_req_word`. Both are held unchanged until the edge at which `ext_req_ready` is 1; in the cycle after that edge `ext_req_valid` is 0.
- R3: The k-th response word (k counted from 0, one per cycle with `ext_rsp_valid` high) belongs to word index (critical index + k) modulo WORDS. In the cycle after its arrival edge it appears on the cache write port: `cwr_en`=1, `cwr_word` = that index, `cwr_data` = the word, `cwr_line` = the miss line. Gaps with `ext_rsp_valid` low produce cycles with `cwr_en`=0. A critical index of 0 gives linear order, and WORDS-1 wraps straight to index 0.
- R4: If the miss was taken with `miss_fwd`=1 and no cancel came first, `fwd_valid` is 1 for exactly one cycle: the cycle in which the critical word is on the cache write port. In that cycle `fwd_data` equals that word. With `miss_fwd`=0, `fwd_valid` stays 0 for the whole fill.
- R5: If `cancel` is 1 in any cycle from the cycle after acceptance up to and including the critical word's write cycle, no `fwd_valid` pulse occurs for that fill. All WORDS array writes and the tag write still happen with unchanged timing.
- R6: `tag_wr_en` is 1 for exactly one cycle, the cycle right after the last word's array write, with `tag_wr_line` equal to the miss line.
- R7: `busy` is 1 and `miss_ready` is 0 from the cycle after acceptance through the tag write cycle. A miss presented during that time is not taken and does not start a request. `miss_ready` returns to 1 in the cycle after the tag write.
- R8: While `busy`, `lfb_hit` is 1 exactly when `lkp_line` equals the line being filled and word `lkp_word` has arrived at an earlier edge. `lfb_data` then gives that word. When not busy, `lfb_hit` is 0.
- R9: `cancel` while idle, or after the critical word was forwarded, has no effect: a later fill still forwards, and the current fill's writes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A miss is presented |
| miss_ready | output | 1 | Unit can take a miss |
| miss_line | input | LINE_AW | Line address of the miss |
| miss_word | input | log2(WORDS) | Index of the critical word |
| miss_fwd | input | 1 | A requester waits for the critical word |
| cancel | input | 1 | The waiting requester has been withdrawn |
| ext_req_valid | output | 1 | Burst read request to external memory |
| ext_req_ready | input | 1 | External memory takes the request |
| ext_req_line | output | LINE_AW | Line address of the burst |
| ext_req_word | output | log2(WORDS) | Starting (critical) word of the burst |
| ext_rsp_valid | input | 1 | A burst data word is present |
| ext_rsp_data | input | DATA_W | Burst data word |
| fwd_valid | output | 1 | Critical word is delivered to the requester |
| fwd_data | output | DATA_W | Critical word |
| cwr_en | output | 1 | Cache data array write |
| cwr_line | output | LINE_AW | Line address of the array write |
| cwr_word | output | log2(WORDS) | Word index of the array write |
| cwr_data | output | DATA_W | Array write data |
| tag_wr_en | output | 1 | Mark the line's tag valid |
| tag_wr_line | output | LINE_AW | Line whose tag is written |
| lkp_line | input | LINE_AW | Lookup line address into the fill buffer |
| lkp_word | input | log2(WORDS) | Lookup word index into the fill buffer |
| lfb_hit | output | 1 | Looked-up word is present in the fill buffer |
| lfb_data | output | DATA_W | Looked-up word |
| busy | output | 1 | A fill is in progress |

## Verification
Two functions can land in the same cycle: the critical word's forward pulse and a withdrawal of the requester. The bench raises `cancel` exactly in the cycle the critical word is on the write port. The forward must vanish at once while the array write still goes out. It also raises `cancel` before any data and after the forward, and checks every write and the tag write against the wrap-around index sequence. A second pair meets in the same cycle: a hit into the fill buffer and a new array write. The bench looks up arrived and missing words while data is still streaming and a competing miss is held on the input.

// File: rtl/lfu_pkg.sv
package lfu_pkg;

  typedef enum logic [2:0] {
    LF_IDLE   = 3'd0,
    LF_REQ    = 3'd1,
    LF_DATA   = 3'd2,
    LF_LAST   = 3'd3,
    LF_COMMIT = 3'd4
  } lf_state_e;

endpackage

// File: rtl/lfu_seq.sv
module lfu_seq
  import lfu_pkg::*;
#(
  parameter  int LINE_AW = 26,
  parameter  int WORDS   = 8,
  localparam int IDX_W   = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  input  logic [LINE_AW-1:0] miss_line,
  input  logic [IDX_W-1:0]   miss_word,
  input  logic               ext_req_ready,
  input  logic               ext_rsp_valid,
  output logic               miss_ready,
  output logic               accept,
  output logic               busy,
  output logic               ext_req_valid,
  output logic [LINE_AW-1:0] cur_line,
  output logic [IDX_W-1:0]   cur_crit,
  output logic               rsp_take,
  output logic               rsp_first,
  output logic [IDX_W-1:0]   rsp_idx,
  output logic               commit
);

  localparam logic [IDX_W:0]   WRAP     = (IDX_W+1)'(WORDS);
  localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(WORDS - 1);

  lf_state_e          state_q, state_d;
  logic [LINE_AW-1:0] line_q, line_d;
  logic [IDX_W-1:0]   crit_q, crit_d;
  logic [IDX_W-1:0]   cnt_q, cnt_d;
  logic [IDX_W:0]     idx_sum;
  logic               rsp_last;

  assign miss_ready    = (state_q == LF_IDLE);
  assign accept        = miss_valid && miss_ready;
  assign busy          = !miss_ready;
  assign ext_req_valid = (state_q == LF_REQ);
  assign rsp_take      = (state_q == LF_DATA) && ext_rsp_valid;
  assign rsp_first     = (cnt_q == '0);
  assign rsp_last      = (cnt_q == LAST_CNT);
  assign commit        = (state_q == LF_COMMIT);
  assign cur_line      = line_q;
  assign cur_crit      = crit_q;

  // wrap-around word index: critical index plus arrival count, modulo WORDS
  assign idx_sum = {1'b0, crit_q} + {1'b0, cnt_q};
  assign rsp_idx = (idx_sum >= WRAP) ? IDX_W'(idx_sum - WRAP) : idx_sum[IDX_W-1:0];

  always_comb begin
    state_d = state_q;
    case (state_q)
      LF_IDLE:   if (accept) state_d = LF_REQ;
      LF_REQ:    if (ext_req_ready) state_d = LF_DATA;
      LF_DATA:   if (rsp_take && rsp_last) state_d = LF_LAST;
      LF_LAST:   state_d = LF_COMMIT;
      LF_COMMIT: state_d = LF_IDLE;
      default:   state_d = LF_IDLE;
    endcase
  end

  always_comb begin
    line_d = line_q;
    crit_d = crit_q;
    cnt_d  = cnt_q;
    if (accept) begin
      line_d = miss_line;
      crit_d = miss_word;
      cnt_d  = '0;
    end else if (rsp_take) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LF_IDLE;
      line_q  <= '0;
      crit_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        line_q <= line_d;
        crit_q <= crit_d;
      end
      if (accept || rsp_take) cnt_q <= cnt_d;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req_valid && !ext_req_ready) |=> (ext_req_valid && $stable(cur_line) && $stable(cur_crit))) else $error("request dropped or changed while waiting"); // R2

  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && busy) |=> $stable(cur_line)) else $error("miss taken while busy"); // R7

endmodule

// File: rtl/lfu_buffer.sv
module lfu_buffer #(
  parameter  int WORDS  = 8,
  parameter  int DATA_W = 32,
  localparam int IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_first,
  output logic              cwr_en,
  output logic [IDX_W-1:0]  cwr_word,
  output logic [DATA_W-1:0] cwr_data,
  output logic              cwr_first,
  input  logic [IDX_W-1:0]  lkp_word,
  output logic              lkp_ok,
  output logic [DATA_W-1:0] lkp_data
);

  logic [WORDS-1:0][DATA_W-1:0] mem_q, mem_d;
  logic [WORDS-1:0]             vld_q, vld_d;
  logic [WORDS-1:0]             wr_sel;
  logic                         stg_v_q, stg_v_d;
  logic [IDX_W-1:0]             stg_idx_q, stg_idx_d;
  logic                         stg_first_q, stg_first_d;

  // one select line per buffer slot
  for (genvar g = 0; g < WORDS; g++) begin : g_sel
    assign wr_sel[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  always_comb begin
    for (int i = 0; i < WORDS; i++) begin
      mem_d[i] = wr_sel[i] ? wr_data : mem_q[i];
    end
  end

  always_comb begin
    vld_d = clr ? '0 : (vld_q | wr_sel);
  end

  always_comb begin
    stg_v_d     = wr_en;
    stg_first_d = wr_en && wr_first;
    stg_idx_d   = wr_en ? wr_idx : stg_idx_q;
  end

  // data slots carry no reset; their valid bits do
  always_ff @(posedge clk) begin
    if (wr_en) mem_q <= mem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q       <= '0;
      stg_v_q     <= 1'b0;
      stg_idx_q   <= '0;
      stg_first_q <= 1'b0;
    end else begin
      if (clr || wr_en) vld_q <= vld_d;
      stg_v_q     <= stg_v_d;
      stg_first_q <= stg_first_d;
      if (wr_en) stg_idx_q <= stg_idx_d;
    end
  end

  assign cwr_en    = stg_v_q;
  assign cwr_word  = stg_idx_q;
  assign cwr_data  = mem_q[stg_idx_q];
  assign cwr_first = stg_first_q;
  assign lkp_ok    = vld_q[lkp_word];
  assign lkp_data  = mem_q[lkp_word];

  AST_NO_REFILL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |-> !vld_q[wr_idx]) else $error("word arrived twice in one fill"); // R3

  AST_WRITE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    cwr_en |-> vld_q[cwr_word]) else $error("array write of a word not in the buffer"); // R3

endmodule

// File: rtl/lfu_fwd.sv
module lfu_fwd #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              arm_fwd,
  input  logic              cancel,
  input  logic              stg_v,
  input  logic              stg_first,
  input  logic [DATA_W-1:0] stg_data,
  output logic              fwd_valid,
  output logic [DATA_W-1:0] fwd_data
);

  logic pend_q, pend_d;
  logic fire;

  // a cancel in the delivery cycle itself still wins
  assign fire      = pend_q && stg_v && stg_first && !cancel;
  assign fwd_valid = fire;
  assign fwd_data  = stg_data;

  always_comb begin
    if (arm) pend_d = arm_fwd;
    else     pend_d = pend_q && !cancel && !fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  AST_FWD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |=> !fwd_valid) else $error("forward pulse longer than one cycle"); // R4

endmodule

// File: rtl/lfu_line_fill.sv
module lfu_line_fill
  import lfu_pkg::*;
#(
  parameter  int LINE_AW = 26,
  parameter  int WORDS   = 8,
  parameter  int DATA_W  = 32,
  localparam int IDX_W   = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [LINE_AW-1:0] miss_line,
  input  logic [IDX_W-1:0]   miss_word,
  input  logic               miss_fwd,
  input  logic               cancel,
  output logic               ext_req_valid,
  input  logic               ext_req_ready,
  output logic [LINE_AW-1:0] ext_req_line,
  output logic [IDX_W-1:0]   ext_req_word,
  input  logic               ext_rsp_valid,
  input  logic [DATA_W-1:0]  ext_rsp_data,
  output logic               fwd_valid,
  output logic [DATA_W-1:0]  fwd_data,
  output logic               cwr_en,
  output logic [LINE_AW-1:0] cwr_line,
  output logic [IDX_W-1:0]   cwr_word,
  output logic [DATA_W-1:0]  cwr_data,
  output logic               tag_wr_en,
  output logic [LINE_AW-1:0] tag_wr_line,
  input  logic [LINE_AW-1:0] lkp_line,
  input  logic [IDX_W-1:0]   lkp_word,
  output logic               lfb_hit,
  output logic [DATA_W-1:0]  lfb_data,
  output logic               busy
);

  logic               accept;
  logic [LINE_AW-1:0] cur_line;
  logic [IDX_W-1:0]   cur_crit;
  logic               rsp_take;
  logic               rsp_first;
  logic [IDX_W-1:0]   rsp_idx;
  logic               commit;
  logic               cwr_first;
  logic               lkp_ok;

  lfu_seq #(.LINE_AW(LINE_AW), .WORDS(WORDS)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .miss_line     (miss_line),
    .miss_word     (miss_word),
    .ext_req_ready (ext_req_ready),
    .ext_rsp_valid (ext_rsp_valid),
    .miss_ready    (miss_ready),
    .accept        (accept),
    .busy          (busy),
    .ext_req_valid (ext_req_valid),
    .cur_line      (cur_line),
    .cur_crit      (cur_crit),
    .rsp_take      (rsp_take),
    .rsp_first     (rsp_first),
    .rsp_idx       (rsp_idx),
    .commit        (commit)
  );

  lfu_buffer #(.WORDS(WORDS), .DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept),
    .wr_en     (rsp_take),
    .wr_idx    (rsp_idx),
    .wr_data   (ext_rsp_data),
    .wr_first  (rsp_first),
    .cwr_en    (cwr_en),
    .cwr_word  (cwr_word),
    .cwr_data  (cwr_data),
    .cwr_first (cwr_first),
    .lkp_word  (lkp_word),
    .lkp_ok    (lkp_ok),
    .lkp_data  (lfb_data)
  );

  lfu_fwd #(.DATA_W(DATA_W)) u_fwd (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (accept),
    .arm_fwd   (miss_fwd),
    .cancel    (cancel),
    .stg_v     (cwr_en),
    .stg_first (cwr_first),
    .stg_data  (cwr_data),
    .fwd_valid (fwd_valid),
    .fwd_data  (fwd_data)
  );

  assign ext_req_line = cur_line;
  assign ext_req_word = cur_crit;
  assign cwr_line     = cur_line;
  assign tag_wr_en    = commit;
  assign tag_wr_line  = cur_line;
  assign lfb_hit      = busy && (lkp_line == cur_line) && lkp_ok;

  // array writes since the last accepted miss, kept for the checks below
  logic [IDX_W:0] wcnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wcnt_q <= '0;
    else if (accept) wcnt_q <= '0;
    else if (cwr_en) wcnt_q <= wcnt_q + 1'b1;
  end

  AST_TAG_AFTER_FULL_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wr_en |-> (wcnt_q == (IDX_W+1)'(WORDS))) else $error("tag written before the line is complete"); // R6

  AST_FWD_WITH_CRIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (cwr_en && cwr_word == cur_crit)) else $error("forward not aligned with critical write"); // R4

  AST_CANCEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && busy && !tag_wr_en) |=> !fwd_valid) else $error("forward after a cancel"); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> (!cwr_en && !ext_req_valid && !tag_wr_en)) else $error("activity while idle"); // R7

endmodule

// File: tb/lfu_line_fill_test.sv
module lfu_line_fill_test;

  localparam int LAW = 26;
  localparam int NW  = 8;
  localparam int DW  = 32;

  logic           clk;
  logic           rst_n;
  logic           miss_valid;
  logic           miss_ready;
  logic [LAW-1:0] miss_line;
  logic [2:0]     miss_word;
  logic           miss_fwd;
  logic           cancel;
  logic           ext_req_valid;
  logic           ext_req_ready;
  logic [LAW-1:0] ext_req_line;
  logic [2:0]     ext_req_word;
  logic           ext_rsp_valid;
  logic [DW-1:0]  ext_rsp_data;
  logic           fwd_valid;
  logic [DW-1:0]  fwd_data;
  logic           cwr_en;
  logic [LAW-1:0] cwr_line;
  logic [2:0]     cwr_word;
  logic [DW-1:0]  cwr_data;
  logic           tag_wr_en;
  logic [LAW-1:0] tag_wr_line;
  logic [LAW-1:0] lkp_line;
  logic [2:0]     lkp_word;
  logic           lfb_hit;
  logic [DW-1:0]  lfb_data;
  logic           busy;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  lfu_line_fill uut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_line(miss_line),
    .miss_word(miss_word), .miss_fwd(miss_fwd), .cancel(cancel),
    .ext_req_valid(ext_req_valid), .ext_req_ready(ext_req_ready),
    .ext_req_line(ext_req_line), .ext_req_word(ext_req_word),
    .ext_rsp_valid(ext_rsp_valid), .ext_rsp_data(ext_rsp_data),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data),
    .cwr_en(cwr_en), .cwr_line(cwr_line), .cwr_word(cwr_word), .cwr_data(cwr_data),
    .tag_wr_en(tag_wr_en), .tag_wr_line(tag_wr_line),
    .lkp_line(lkp_line), .lkp_word(lkp_word), .lfb_hit(lfb_hit), .lfb_data(lfb_data),
    .busy(busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dat(input logic [LAW-1:0] l, input int i);
    return 32'hC0DE0000 ^ {l[11:0], 4'h5, 13'h0, 3'(i)};
  endfunction

  task automatic next_cycle();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_inputs();
    miss_valid = 0; miss_line = '0; miss_word = '0; miss_fwd = 0;
    cancel = 0; ext_req_ready = 0; ext_rsp_valid = 0; ext_rsp_data = '0;
    lkp_line = '1; lkp_word = '0;
  endtask

  // cmode: 0 none, 1 cancel before data, 2 cancel in the critical write cycle, 3 cancel after forward
  task automatic run_fill(input logic [LAW-1:0] line, input int crit, input bit want_fwd,
                          input int cmode, input bit gaps);
    int  k_taken;
    int  prev;
    int  c;
    bit  cancelled;
    bit  exp_fwd;
    int  widx;
    cancelled = 0;
    miss_valid = 1; miss_line = line; miss_word = 3'(crit); miss_fwd = want_fwd;
    #1;
    chk(miss_ready == 1, "R7", "ready when idle", 64'(miss_ready), 1);
    next_cycle();
    miss_valid = 0;
    #1;
    chk(ext_req_valid == 1 && busy == 1, "R2", "request raised", 64'(ext_req_valid), 1);
    chk(ext_req_line == line, "R2", "request line", 64'(ext_req_line), 64'(line));
    chk(ext_req_word == 3'(crit), "R2", "request word", 64'(ext_req_word), 64'(crit));
    next_cycle();
    #1;
    chk(ext_req_valid == 1 && ext_req_line == line && ext_req_word == 3'(crit), "R2",
        "request held while not ready", 64'(ext_req_valid), 1);
    ext_req_ready = 1;
    if (cmode == 1) begin cancel = 1; cancelled = 1; end
    next_cycle();
    ext_req_ready = 0;
    cancel = 0;
    #1;
    chk(ext_req_valid == 0, "R2", "request dropped after handshake", 64'(ext_req_valid), 0);
    k_taken = 0;
    prev = -1;
    c = 0;
    while (k_taken < NW || prev >= 0) begin
      // competing miss held on the input during the fill
      miss_valid = 1; miss_line = line ^ 26'h1; miss_word = 3'(crit + 1);
      cancel = (cmode == 2 && prev == 0) || (cmode == 3 && prev == 3);
      if (cancel && prev <= 0) cancelled = 1;
      ext_rsp_valid = (k_taken < NW) && !(gaps && (c % 2 == 1));
      ext_rsp_data = ext_rsp_valid ? dat(line, (crit + k_taken) % NW) : 32'hDEAD_BEEF;
      lkp_line = line;
      lkp_word = 3'(crit + 1);
      #1;
      chk(miss_ready == 0 && ext_req_valid == 0, "R7", "competing miss held off",
          64'(miss_ready), 0);
      if (prev >= 0) begin
        widx = (crit + prev) % NW;
        chk(cwr_en == 1, "R3", "array write enable", 64'(cwr_en), 1);
        chk(cwr_word == 3'(widx), "R3", "array write index", 64'(cwr_word), 64'(widx));
        chk(cwr_data == dat(line, widx), "R3", "array write data", 64'(cwr_data),
            64'(dat(line, widx)));
        chk(cwr_line == line, "R3", "array write line", 64'(cwr_line), 64'(line));
      end else begin
        chk(cwr_en == 0, "R3", "no write in gap", 64'(cwr_en), 0);
      end
      exp_fwd = (prev == 0) && want_fwd && !cancelled;
      chk(fwd_valid == exp_fwd, (cmode == 0) ? "R4" : ((cmode == 3) ? "R9" : "R5"),
          "forward pulse", 64'(fwd_valid), 64'(exp_fwd));
      if (exp_fwd)
        chk(fwd_data == dat(line, crit), "R4", "forward data", 64'(fwd_data),
            64'(dat(line, crit)));
      // fill buffer lookups while words stream in
      chk(lfb_hit == (k_taken > 1), "R8", "hit on second word", 64'(lfb_hit), 64'(k_taken > 1));
      if (k_taken > 1)
        chk(lfb_data == dat(line, (crit + 1) % NW), "R8", "hit data", 64'(lfb_data),
            64'(dat(line, (crit + 1) % NW)));
      if (k_taken == 3) begin
        lkp_word = 3'(crit + 6);
        #1;
        chk(lfb_hit == 0, "R8", "no hit on missing word", 64'(lfb_hit), 0);
        lkp_line = line ^ 26'h4;
        lkp_word = 3'(crit);
        #1;
        chk(lfb_hit == 0, "R8", "no hit on other line", 64'(lfb_hit), 0);
      end
      prev = ext_rsp_valid ? k_taken : -1;
      if (ext_rsp_valid) k_taken++;
      c++;
      next_cycle();
    end
    ext_rsp_valid = 0;
    cancel = 0;
    miss_valid = 0;
    lkp_line = line;
    lkp_word = 3'(crit);
    #1;
    chk(tag_wr_en == 1 && tag_wr_line == line, "R6", "tag write after last word",
        64'(tag_wr_en), 1);
    chk(cwr_en == 0 && fwd_valid == 0, "R6", "no write in tag cycle", 64'(cwr_en), 0);
    chk(miss_ready == 0, "R7", "still busy in tag cycle", 64'(miss_ready), 0);
    next_cycle();
    #1;
    chk(miss_ready == 1 && busy == 0, "R7", "ready after tag write", 64'(miss_ready), 1);
    chk(tag_wr_en == 0, "R6", "tag pulse single", 64'(tag_wr_en), 0);
    chk(lfb_hit == 0, "R8", "no hit when idle", 64'(lfb_hit), 0);
  endtask

  task automatic test_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1;
    next_cycle();
    #1;
    chk(miss_ready == 1 && busy == 0, "R1", "ready after reset", 64'(miss_ready), 1);
    chk(ext_req_valid == 0 && cwr_en == 0, "R1", "quiet after reset", 64'(ext_req_valid), 0);
    chk(fwd_valid == 0 && tag_wr_en == 0, "R1", "no pulses after reset", 64'(fwd_valid), 0);
  endtask

  task automatic test_basic();       run_fill(26'h0123456, 3, 1, 0, 0); endtask
  task automatic test_linear_gaps(); run_fill(26'h0000A10, 0, 1, 0, 1); endtask
  task automatic test_wrap_store();  run_fill(26'h3FFFF01, 7, 0, 0, 0); endtask
  task automatic test_cancel_early(); run_fill(26'h0055500, 5, 1, 1, 1); endtask
  task automatic test_cancel_same(); run_fill(26'h1234567, 2, 1, 2, 0); endtask
  task automatic test_cancel_late(); run_fill(26'h0ABCDEF, 6, 1, 3, 0); endtask

  task automatic test_idle_cancel();
    cancel = 1;
    repeat (3) begin
      #1;
      chk(busy == 0 && ext_req_valid == 0, "R9", "idle cancel inert", 64'(busy), 0);
      next_cycle();
    end
    cancel = 0;
    run_fill(26'h0F0F0F0, 4, 1, 0, 0);   // R9 forward still delivered
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    test_reset();
    test_basic();
    test_linear_gaps();
    test_wrap_store();
    test_cancel_early();
    test_cancel_same();
    test_cancel_late();
    test_idle_cancel();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule